// File: doc/BRIEF.md
# Register-Programmed SPI Flash Host

This block is a half-duplex SPI host for a serial flash device, controlled by a CPU through a small 32-bit register bus. Software drives two chip-select pins and picks which one the shifter works for. It sets a transfer length of one to four bytes, polls a ready flag, and then accesses a single data register. Writing that register clocks bytes out on MOSI. Reading it clocks bytes in from MISO and stalls the bus until the last bit has arrived.

The serial clock comes from the system clock divided by a programmable divisor. The link runs in SPI mode 0: SCLK idles low, MISO is sampled as SCLK rises, and MOSI changes as SCLK falls, most significant bit first. Two configuration bits choose the byte-lane order, one for reads and one for writes. In big-endian order the first byte on the wire is the top lane, bits 31:24, and the lanes that follow go downward. In little-endian order the first byte is the bottom lane, bits 7:0, and the lanes that follow go upward.

The register bus is a valid/ready interface. The CPU holds `cpu_valid` and its request fields steady until it samples `cpu_ready` high at a rising clock edge, and the access completes on that edge. For reads, `cpu_rdata` is valid in that same cycle. Every access completes without stalling except a read of the data register. That read holds `cpu_ready` low until the whole receive transfer has finished, and it also waits behind any transfer already running.

Top module: `spi_flash_host`

## Requirements
- R1: After reset, the status register (offset 0x08) reads 0xC800_0000: both chip-select levels are 1, the length is 0, ready is 1 and routing is 0. The configuration register (offset 0x00) reads 0x0000_0004. Both chip-select pins are high and SCLK is low.
- R2: Register fields. Configuration: bit 28 selects big-endian order for reads, bit 27 selects big-endian order for writes, and bits 7:0 hold the divisor. Status: bit 31 is the chip-select 0 level, bit 30 the chip-select 1 level, bits 29:28 the length code, bit 27 the read-only ready flag, and bit 24 the routing bit. All other bits read as 0.
- R3: The ready flag reads 0 from the clock edge that accepts a data-register access until the last SCLK falling edge of that transfer, and reads 1 after that.
- R4: A data-register write sends length code + 1 bytes in SPI mode 0, most significant bit first. SCLK idles low, and MOSI changes only when SCLK falls. The number of SCLK pulses is 8 × (code + 1).
- R5: With configuration bit 27 set, the transmit bytes come from bits 31:24 downward, so a one-byte write sends bits 31:24.
- R6: With configuration bit 27 clear, the transmit bytes come from bits 7:0 upward.
- R7: A data-register read holds `cpu_ready` low until all requested bytes have been shifted in, and keeps MOSI low throughout. With configuration bit 28 set, the bytes are returned from bits 31:24 downward and unused lanes read as 0.
- R8: With configuration bit 28 clear, received bytes are returned from bits 7:0 upward, and unused lanes read as 0.
- R9: One SCLK period lasts D system clocks: ceil(D/2) low followed by floor(D/2) high, where D is the divisor field. A divisor below 2 acts as 2.
- R10: While the ready flag is 0, writes to the data register and to the length field have no effect. Status bits 31, 30 and 24 still take the written value.
- R11: With routing 0, `cs0_n` follows status bit 31 and `cs1_n` is held high. With routing 1, `cs1_n` follows bit 30 and `cs0_n` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Register access request |
| cpu_ready | output | 1 | Access completes on this edge when high with cpu_valid |
| cpu_write | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 4 | Byte offset of the register |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid when cpu_valid and cpu_ready |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| cs0_n | output | 1 | Chip select 0, active low |
| cs1_n | output | 1 | Chip select 1, active low |

## Verification
The hardest case to reach from the ports is an access that arrives while a transfer is already in flight. The aim is to show that a second data write and a length change are both dropped, while a chip-select change made in the same window takes effect at once. To get there, the stimulus issues those register writes on back-to-back bus cycles straight after a four-byte write. It then checks the chip-select pin before the shifter finishes, and afterwards checks the captured wire bits and the length field read back. The little-endian receive path is covered with an odd byte count, so that both the lane mirroring and the zero fill of unused lanes are visible in one result.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int DATA_W = 32;
  localparam int NB     = DATA_W / 8;
  localparam int LEN_W  = $clog2(NB);
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFF_CFG  = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_CSR  = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_DATA = 4'hC;

  localparam int CFG_RD_BE = 28;
  localparam int CFG_WR_BE = 27;
  localparam int CSR_CS0   = 31;
  localparam int CSR_CS1   = 30;
  localparam int CSR_LEN   = 28;
  localparam int CSR_RDY   = 27;
  localparam int CSR_ROUTE = 24;

  typedef enum logic [1:0] {RD_IDLE, RD_WAIT, RD_DONE} rd_state_t;

  function automatic logic [DATA_W-1:0] lane_swap(input logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < NB; i++) r[8*i +: 8] = w[8*(NB-1-i) +: 8];
    return r;
  endfunction
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             sclk,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] div_eff, low_len, high_len, cnt;

  always_comb begin
    div_eff  = (divisor < DIV_W'(2)) ? DIV_W'(2) : divisor;
    high_len = div_eff >> 1;
    low_len  = div_eff - high_len;
  end

  assign rise_tick = run && !sclk && (cnt == low_len - 1'b1);
  assign fall_tick = run &&  sclk && (cnt == high_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (rise_tick) begin
      cnt  <= '0;
      sclk <= 1'b1;
    end else if (fall_tick) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9: a phase never ends on both edges at once
  a_r9_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_tick && fall_tick));
  // R9: the level toggles only on a tick
  a_r9_sclk_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !rise_tick && !fall_tick) |=> $stable(sclk));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_rx,
  input  logic [LEN_W-1:0]  len_code,
  input  logic              big_end,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_sr, rx_sr, aligned;
  logic [CNT_W-1:0]  bitcnt, last_q;
  logic [LEN_W-1:0]  len_q;
  logic              rx_q, be_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      tx_sr  <= '0;
      rx_sr  <= '0;
      bitcnt <= '0;
      last_q <= '0;
      len_q  <= '0;
      rx_q   <= 1'b0;
      be_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy   <= 1'b1;
        rx_q   <= dir_rx;
        be_q   <= big_end;
        len_q  <= len_code;
        last_q <= {len_code, 3'b111};
        bitcnt <= '0;
        rx_sr  <= '0;
        tx_sr  <= big_end ? tx_word : lane_swap(tx_word);
      end else if (busy) begin
        if (rise_tick) rx_sr <= {rx_sr[DATA_W-2:0], miso};
        if (fall_tick) begin
          tx_sr <= tx_sr << 1;
          if (bitcnt == last_q) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
      end
    end
  end

  assign mosi = busy && !rx_q && tx_sr[DATA_W-1];

  always_comb begin
    aligned = rx_sr << (8 * (NB - 1 - int'(len_q)));
    rx_word = be_q ? aligned : lane_swap(aligned);
  end

  // R4: the bit counter never runs past the requested length
  a_r4_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bitcnt <= last_q));
  // R4: a transfer ends only on a falling edge of SCLK
  a_r4_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(fall_tick));
endmodule

// File: rtl/spi_flash_host.sv
module spi_flash_host
  import spi_host_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs0_n,
  output logic              cs1_n
);
  logic             rd_be, wr_be;
  logic [DIV_W-1:0] div_q;
  logic             cs0_lvl, cs1_lvl, route;
  logic [LEN_W-1:0] len_q;
  rd_state_t        rd_state;

  logic              eng_busy, eng_done, rise_tick, fall_tick;
  logic [DATA_W-1:0] eng_rx;
  logic              is_data_rd, wr_cfg, wr_csr, tx_start, rx_start;

  assign is_data_rd = cpu_valid && !cpu_write && (cpu_addr == OFF_DATA);
  assign wr_cfg     = cpu_valid && cpu_write && (cpu_addr == OFF_CFG);
  assign wr_csr     = cpu_valid && cpu_write && (cpu_addr == OFF_CSR);
  assign tx_start   = cpu_valid && cpu_write && (cpu_addr == OFF_DATA) && !eng_busy;
  assign rx_start   = is_data_rd && !eng_busy && (rd_state == RD_IDLE);
  assign cpu_ready  = !is_data_rd || (rd_state == RD_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_be   <= 1'b0;
      wr_be   <= 1'b0;
      div_q   <= DIV_W'(DIV_RESET);
      cs0_lvl <= 1'b1;
      cs1_lvl <= 1'b1;
      route   <= 1'b0;
      len_q   <= '0;
    end else begin
      if (wr_cfg) begin
        rd_be <= cpu_wdata[CFG_RD_BE];
        wr_be <= cpu_wdata[CFG_WR_BE];
        div_q <= cpu_wdata[DIV_W-1:0];
      end
      if (wr_csr) begin
        cs0_lvl <= cpu_wdata[CSR_CS0];
        cs1_lvl <= cpu_wdata[CSR_CS1];
        route   <= cpu_wdata[CSR_ROUTE];
        if (!eng_busy) len_q <= cpu_wdata[CSR_LEN +: LEN_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_state <= RD_IDLE;
    else begin
      case (rd_state)
        RD_IDLE: if (rx_start) rd_state <= RD_WAIT;
        RD_WAIT: if (eng_done) rd_state <= RD_DONE;
        default: rd_state <= RD_IDLE;
      endcase
    end
  end

  always_comb begin
    cpu_rdata = '0;
    case (cpu_addr)
      OFF_CFG: begin
        cpu_rdata[CFG_RD_BE]   = rd_be;
        cpu_rdata[CFG_WR_BE]   = wr_be;
        cpu_rdata[DIV_W-1:0]   = div_q;
      end
      OFF_CSR: begin
        cpu_rdata[CSR_CS0]            = cs0_lvl;
        cpu_rdata[CSR_CS1]            = cs1_lvl;
        cpu_rdata[CSR_LEN +: LEN_W]   = len_q;
        cpu_rdata[CSR_RDY]            = !eng_busy;
        cpu_rdata[CSR_ROUTE]          = route;
      end
      OFF_DATA: cpu_rdata = eng_rx;
      default:  cpu_rdata = '0;
    endcase
  end

  assign cs0_n = route ? 1'b1 : cs0_lvl;
  assign cs1_n = route ? cs1_lvl : 1'b1;

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (eng_busy),
    .divisor   (div_q),
    .sclk      (sclk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  spi_shift_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (tx_start || rx_start),
    .dir_rx    (rx_start),
    .len_code  (len_q),
    .big_end   (rx_start ? rd_be : wr_be),
    .tx_word   (cpu_wdata),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .miso      (miso),
    .busy      (eng_busy),
    .done      (eng_done),
    .mosi      (mosi),
    .rx_word   (eng_rx)
  );

  // R3: status never reports ready while the shifter runs
  a_r3_not_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_write && cpu_addr == OFF_CSR && eng_busy) |-> !cpu_rdata[CSR_RDY]);
  // R4: SCLK rests low whenever no transfer runs
  a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> !sclk);
  // R7: a pending data read stalls the bus and keeps MOSI low
  a_r7_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_state == RD_WAIT) |-> (!mosi && !(is_data_rd && cpu_ready)));
  // R10: the length field holds while a transfer is in flight
  a_r10_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && $past(eng_busy)) |-> $stable(len_q));
  // R11: at most one chip select is driven low
  a_r11_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~cs0_n, ~cs1_n}) <= 1);
endmodule

// File: tb/test_spi_flash_host.sv
module test_spi_flash_host;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [3:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        sclk, mosi, miso, cs0_n, cs1_n;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_flash_host i_spi_flash_host (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs0_n(cs0_n), .cs1_n(cs1_n));

  // flash model: capture MOSI on rising SCLK, present MISO bit by bit
  int          cyc = 0, rises = 0, base = 0;
  int          last_rise = 0, prev_rise = 0, last_fall = 0;
  logic [31:0] cap = '0, slave_word = '0;
  always @(posedge clk) cyc = cyc + 1;
  always @(posedge sclk) begin
    cap <= {cap[30:0], mosi};
    rises <= rises + 1;
    prev_rise <= last_rise;
    last_rise <= cyc;
  end
  always @(negedge sclk) last_fall <= cyc;
  assign miso = ((rises - base) < 32 && (rises - base) >= 0) ? slave_word[31 - (rises - base)] : 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    cpu_valid = 1; cpu_write = 1; cpu_addr = a; cpu_wdata = d;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cpu_valid = 0; cpu_write = 0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] d, output int waits);
    @(negedge clk);
    cpu_valid = 1; cpu_write = 0; cpu_addr = a;
    waits = 0;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; waits++; end
    d = cpu_rdata;
    @(negedge clk);
    cpu_valid = 0;
  endtask

  task automatic wait_ready();
    logic [31:0] v; int w;
    do bus_read(4'h8, v, w); while (!v[27]);
  endtask

  function automatic logic [31:0] lowmask(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
  endfunction

  // write transfer: returns captured wire bits and pulse count
  task automatic do_tx(logic [1:0] len, logic [31:0] d, output logic [31:0] got, output int nb);
    logic [31:0] st; int w;
    bus_write(4'h8, 32'h4000_0000 | (32'(len) << 28));
    base = rises;
    bus_write(4'hC, d);
    bus_read(4'h8, st, w);
    check("R3 ready low during write transfer", {31'b0, st[27]}, 32'h0);
    wait_ready();
    nb  = rises - base;
    got = cap & lowmask(nb);
  endtask

  task automatic do_rx(logic [1:0] len, logic [31:0] sw, output logic [31:0] got, output int waits);
    bus_write(4'h8, 32'h4000_0000 | (32'(len) << 28));
    slave_word = sw;
    base = rises;
    bus_read(4'hC, got, waits);
  endtask

  task automatic t_reset();
    logic [31:0] v; int w;
    bus_read(4'h8, v, w); check("R1 status reset", v, 32'hC800_0000);
    bus_read(4'h0, v, w); check("R1 config reset", v, 32'h0000_0004);
    check("R1 pins idle", {29'b0, cs0_n, cs1_n, sclk}, 32'h6);
  endtask

  task automatic t_tx_be();
    logic [31:0] g; int n;
    bus_write(4'h0, 32'h1800_0004);
    do_tx(2'd3, 32'hA1B2_C3D4, g, n);
    check("R4 four-byte pulse count", n, 32);
    check("R5 four-byte BE wire data", g, 32'hA1B2_C3D4);
    do_tx(2'd0, 32'h5A11_2233, g, n);
    check("R4 one-byte pulse count", n, 8);
    check("R5 one-byte takes top lane", g, 32'h5A);
    do_tx(2'd2, 32'h1122_33FF, g, n);
    check("R4 three-byte pulse count", n, 24);
    check("R5 three-byte BE wire data", g, 32'h112233);
    check("R4 SCLK idle low after", {31'b0, sclk}, 0);
  endtask

  task automatic t_rx_be();
    logic [31:0] g; int w;
    bus_write(4'h0, 32'h1800_0004);
    do_rx(2'd3, 32'h1234_5678, g, w);
    check("R7 four-byte BE read", g, 32'h1234_5678);
    check("R7 bus stalled", {31'b0, w > 0}, 1);
    check("R7 MOSI low during read", cap, 0);
    do_rx(2'd0, 32'h9CFF_FFFF, g, w);
    check("R7 one-byte read in top lane", g, 32'h9C00_0000);
  endtask

  task automatic t_le();
    logic [31:0] g; int n;
    bus_write(4'h0, 32'h0000_0004);
    do_tx(2'd1, 32'h0000_BEEF, g, n);
    check("R6 two-byte LE wire order", g, 32'hEFBE);
    do_rx(2'd2, 32'h1122_3300, g, n);
    check("R8 three-byte LE read placement", g, 32'h0033_2211);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v; int w, nb;
    bus_write(4'h0, 32'h1800_0004);
    bus_write(4'h8, 32'h7000_0000);
    base = rises;
    bus_write(4'hC, 32'hA5A5_0F0F);
    bus_write(4'hC, 32'hFFFF_FFFF);
    bus_write(4'h8, 32'hC000_0000);
    check("R10 chip select writable while busy", {31'b0, cs0_n}, 1);
    wait_ready();
    nb = rises - base;
    check("R10 second write adds no bits", nb, 32);
    check("R10 data write ignored while busy", cap, 32'hA5A5_0F0F);
    bus_read(4'h8, v, w);
    check("R10 length kept while busy", v, 32'hF800_0000);
  endtask

  task automatic t_divisor();
    logic [31:0] g; int n;
    bus_write(4'h0, 32'h1800_0005);
    do_tx(2'd0, 32'h8000_0000, g, n);
    check("R9 period at divisor 5", last_rise - prev_rise, 5);
    check("R9 high time at divisor 5", last_fall - last_rise, 2);
    bus_write(4'h0, 32'h1800_0000);
    do_tx(2'd0, 32'h0100_0000, g, n);
    check("R9 divisor 0 acts as 2", last_rise - prev_rise, 2);
    check("R4 data at fast rate", g, 32'h01);
  endtask

  task automatic t_route();
    logic [31:0] v; int w;
    bus_write(4'h8, 32'h0100_0000);
    check("R11 route 1 holds cs0 high", {30'b0, cs0_n, cs1_n}, 32'h2);
    bus_write(4'h8, 32'h4100_0000);
    check("R11 route 1 cs1 follows level", {30'b0, cs0_n, cs1_n}, 32'h3);
    bus_write(4'h8, 32'h0000_0000);
    check("R11 route 0 holds cs1 high", {30'b0, cs0_n, cs1_n}, 32'h1);
    bus_read(4'h8, v, w);
    check("R2 status fields read back", v, 32'h0800_0000);
    bus_write(4'h0, 32'h1000_0033);
    bus_read(4'h0, v, w);
    check("R2 config fields read back", v, 32'h1000_0033);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_tx_be();
    t_rx_be();
    t_le();
    t_busy_ignore();
    t_divisor();
    t_route();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule